// File: doc/BRIEF.md
# Sticky Event Flag Bank with Combined Event Outputs

This block latches single-cycle pulses from a large set of system events into sticky flag bits. The flags are grouped into words of `WORD_W` bits, with `NUM_WORDS` words in total. By default there are four 32-bit words, which covers 128 events. A flag goes to 1 on the first pulse of its event and stays at 1 until software clears it. Pulses are latched whether or not the event is masked.

Software reaches the bank through one write port and one read port, both addressed by a register kind and a word index:

- The flag words can only be read.
- Flags are cleared through a write-one-to-clear register.
- Flags are forced to 1 through a write-one-to-set register. This works even when the event is masked.

For each word, the block drives one registered combined-event output. That output reflects only the flags whose mask bit is 0. A downstream interrupt router can use these outputs as event sources.

Top module: `evt_flag_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all flags, `comb_evt` and `rd_data` become 0.
- R2: A 1 on `evt_pulse[n]` at a rising edge sets flag n at that edge, whatever the value of `evt_mask[n]`.
- R3: A flag that is 1 stays 1 until a clear write with a 1 in its bit position.
- R4: A write with kind 2'b10 (clear) to word w clears, at that edge, every flag bit of word w whose `wr_data` bit is 1. The address is `wr_addr` = {kind[1:0], word index}.
- R5: A write with kind 2'b01 (set) to word w sets, at that edge, every flag bit of word w whose `wr_data` bit is 1. Masked bits are set as well.
- R6: After each edge, `comb_evt[w]` equals the OR over word w of (flag AND NOT mask). The flags used are those after the edge, and the mask is the one sampled at that edge. Masked flags never raise it.
- R7: If an event pulse and a clear of the same bit arrive at the same edge, the flag is 1 afterwards.
- R8: Bits written as 0 to the set or clear register leave the corresponding flags unchanged.
- R9: Writes with kind 2'b00 (flag word) or 2'b11 (reserved), and writes to a word index of `NUM_WORDS` or above, change no flag.
- R10: One edge after a read address is presented, `rd_data` holds the flag word as it stood before that edge when the kind is 2'b00. For kinds 2'b01, 2'b10 and 2'b11, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_WORDS*WORD_W | Single-cycle event pulses, one bit per event |
| evt_mask | input | NUM_WORDS*WORD_W | 1 excludes the event from its combined output |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2+WSEL_W | Write address: {kind, word index} |
| wr_data | input | WORD_W | Write data: bit mask for set or clear |
| rd_addr | input | 2+WSEL_W | Read address: {kind, word index} |
| rd_data | output | WORD_W | Registered read data |
| comb_evt | output | NUM_WORDS | Registered combined event, one per word |

## Verification
The bench uses the default build of four 32-bit words, so all 128 event bits and every word index are exercised. Because the word count is a power of two, each index the 2-bit field can hold selects a real word. Directed cases cover masked capture, event-versus-clear collisions, zero-bit writes, writes to the read-only and reserved kinds, and reads of the write-only kinds. A long random run then mixes sparse pulses, random masks and writes and reads of every kind against a bench model of the flag array.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  typedef enum logic [1:0] {
    KIND_FLAG = 2'b00,
    KIND_SET  = 2'b01,
    KIND_CLR  = 2'b10,
    KIND_RSVD = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/evt_flag_word.sv
module evt_flag_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ev,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] set_bits,
  input  logic [WORD_W-1:0] clr_bits,
  output logic [WORD_W-1:0] flags,
  output logic              comb
);
  logic [WORD_W-1:0] flag_q, flag_next;
  logic              comb_q;

  // event and set dominate clear
  always_comb flag_next = (flag_q & ~clr_bits) | set_bits | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      comb_q <= 1'b0;
    end else begin
      flag_q <= flag_next;
      comb_q <= |(flag_next & ~mask);
    end
  end

  assign flags = flag_q;
  assign comb  = comb_q;
endmodule

// File: rtl/evt_flag_rdmux.sv
module evt_flag_rdmux
  import evt_flag_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int WSEL_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WORDS*WORD_W-1:0] flag_vec,
  input  logic [WSEL_W+1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data
);
  logic [WORD_W-1:0] rd_next, rd_q;
  reg_kind_e         kind;
  logic [WSEL_W-1:0] idx;

  always_comb begin
    kind    = reg_kind_e'(rd_addr[WSEL_W+1:WSEL_W]);
    idx     = rd_addr[WSEL_W-1:0];
    rd_next = '0;
    if (kind == KIND_FLAG) begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (idx == WSEL_W'(k)) rd_next = flag_vec[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_flag_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W,
  localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W   = WSEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_mask,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  output logic [NUM_WORDS-1:0] comb_evt
);
  reg_kind_e         wr_kind;
  logic [WSEL_W-1:0] wr_word;
  logic [NUM_EVT-1:0] flag_vec;

  assign wr_kind = reg_kind_e'(wr_addr[ADDR_W-1 -: 2]);
  assign wr_word = wr_addr[WSEL_W-1:0];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic              hit;
    logic [WORD_W-1:0] set_bits, clr_bits;

    assign hit      = wr_en && (wr_word == WSEL_W'(g));
    assign set_bits = (hit && wr_kind == KIND_SET) ? wr_data : '0;
    assign clr_bits = (hit && wr_kind == KIND_CLR) ? wr_data : '0;

    evt_flag_word #(.WORD_W(WORD_W)) u_word (
      .clk      (clk),
      .rst      (rst),
      .ev       (evt_pulse[g*WORD_W +: WORD_W]),
      .mask     (evt_mask[g*WORD_W +: WORD_W]),
      .set_bits (set_bits),
      .clr_bits (clr_bits),
      .flags    (flag_vec[g*WORD_W +: WORD_W]),
      .comb     (comb_evt[g])
    );
  end

  evt_flag_rdmux #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .WSEL_W    (WSEL_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .flag_vec (flag_vec),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/evt_flag_chk.sv
module evt_flag_chk #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W,
  localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W   = WSEL_W + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_EVT-1:0]   evt_pulse,
  input logic [NUM_EVT-1:0]   evt_mask,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [WORD_W-1:0]    wr_data,
  input logic [NUM_EVT-1:0]   flag_vec,
  input logic [NUM_WORDS-1:0] comb_evt
);
  logic [NUM_EVT-1:0] set_vec, clr_vec, wide_data;

  always_comb begin
    wide_data = NUM_EVT'(wr_data);
    set_vec   = '0;
    clr_vec   = '0;
    if (wr_en && int'(wr_addr[WSEL_W-1:0]) < NUM_WORDS) begin
      if (wr_addr[ADDR_W-1 -: 2] == 2'b01)
        set_vec = wide_data << (int'(wr_addr[WSEL_W-1:0]) * WORD_W);
      if (wr_addr[ADDR_W-1 -: 2] == 2'b10)
        clr_vec = wide_data << (int'(wr_addr[WSEL_W-1:0]) * WORD_W);
    end
  end

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((flag_vec & $past(evt_pulse)) == $past(evt_pulse)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_vec & ~clr_vec)) |=> ((~flag_vec & $past(flag_vec & ~clr_vec)) == '0));

  // R4
  clear_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~evt_pulse)) |=> ((flag_vec & $past(clr_vec & ~evt_pulse)) == '0));

  // R5
  set_force_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flag_vec & $past(set_vec)) == $past(set_vec)));

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_comb
    // R6
    comb_match_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (comb_evt[g] ==
        |(flag_vec[g*WORD_W +: WORD_W] & ~$past(evt_mask[g*WORD_W +: WORD_W]))));
  end
endmodule

bind evt_flag_bank evt_flag_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_pulse (evt_pulse),
  .evt_mask  (evt_mask),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .flag_vec  (flag_vec),
  .comb_evt  (comb_evt)
);

// File: tb/sim_evt_flag_bank.sv
module sim_evt_flag_bank;
  localparam int NW = 4;
  localparam int W  = 32;
  localparam int N  = NW * W;
  localparam int WS = 2;
  localparam int AW = WS + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt_pulse = '0;
  logic [N-1:0]  evt_mask = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [NW-1:0] comb_evt;

  int n_chk = 0;
  int n_err = 0;
  logic [N-1:0] m_flag = '0;

  always #2 clk = ~clk;

  evt_flag_bank #(.NUM_WORDS(NW), .WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .evt_mask(evt_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .comb_evt(comb_evt)
  );

  function automatic logic [AW-1:0] adr(input logic [1:0] kind, input int idx);
    return {kind, WS'(idx)};
  endfunction

  function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
    int idx = int'(a[WS-1:0]);
    if (a[AW-1 -: 2] == 2'b00 && idx < NW) return m_flag[idx*W +: W];
    return '0;
  endfunction

  function automatic logic [NW-1:0] m_comb(input logic [N-1:0] mk);
    logic [NW-1:0] c;
    for (int w = 0; w < NW; w++) c[w] = |(m_flag[w*W +: W] & ~mk[w*W +: W]);
    return c;
  endfunction

  task automatic m_step(input logic [N-1:0] ev, input logic we,
                        input logic [AW-1:0] wa, input logic [W-1:0] wd);
    logic [N-1:0] sv = '0;
    logic [N-1:0] cv = '0;
    int idx = int'(wa[WS-1:0]);
    if (we && idx < NW) begin
      if (wa[AW-1 -: 2] == 2'b01) sv[idx*W +: W] = wd;
      if (wa[AW-1 -: 2] == 2'b10) cv[idx*W +: W] = wd;
    end
    m_flag = (m_flag & ~cv) | sv | ev;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, check one edge later
  task automatic cyc(input string req, input logic [N-1:0] ev, input logic [N-1:0] mk,
                     input logic we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                     input logic [AW-1:0] ra);
    logic [W-1:0]  exp_rd;
    logic [NW-1:0] exp_cb;
    evt_pulse = ev; evt_mask = mk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    exp_rd = m_read(ra);
    m_step(ev, we, wa, wd);
    exp_cb = m_comb(mk);
    @(posedge clk);
    @(negedge clk);
    check(req, "rd_data", 64'(rd_data), 64'(exp_rd));
    check(req, "comb_evt", 64'(comb_evt), 64'(exp_cb));
  endtask

  task automatic idle_rd(input string req, input logic [N-1:0] mk, input int idx);
    cyc(req, '0, mk, 1'b0, '0, '0, adr(2'b00, idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [N-1:0] ones;
    logic [N-1:0] b37, b3, m2;
    void'($urandom(32'd20240611));
    ones = '1;
    b37 = '0; b37[37] = 1'b1;
    b3 = '0; b3[3] = 1'b1;
    m2 = '0; m2[2*W +: W] = '1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible through reads and comb outputs
    for (int i = 0; i < NW; i++) idle_rd("R1", '0, i);

    // R2: masked event still sets its flag; comb stays low
    cyc("R2", b37, b37, 1'b0, '0, '0, adr(2'b00, 1));
    idle_rd("R2", b37, 1);
    check("R2", "word1", 64'(rd_data), 64'h20);
    // R3: flag holds over idle cycles
    for (int i = 0; i < 4; i++) idle_rd("R3", b37, 1);
    // R6: unmasked event raises comb, then masking drops it
    cyc("R6", b3, b37, 1'b0, '0, '0, adr(2'b00, 0));
    check("R6", "comb0 high", 64'(comb_evt[0]), 64'h1);
    idle_rd("R6", b37 | b3, 0);
    check("R6", "comb0 masked", 64'(comb_evt[0]), 64'h0);
    // R4: clear word1 bit5
    cyc("R4", '0, '0, 1'b1, adr(2'b10, 1), 32'h20, adr(2'b00, 1));
    idle_rd("R4", '0, 1);
    check("R4", "word1 cleared", 64'(rd_data), 64'h0);
    // R8: zero bits in clear/set writes change nothing
    cyc("R8", '0, '0, 1'b1, adr(2'b10, 0), 32'h0, adr(2'b00, 0));
    cyc("R8", '0, '0, 1'b1, adr(2'b01, 0), 32'h0, adr(2'b00, 0));
    idle_rd("R8", '0, 0);
    check("R8", "word0", 64'(rd_data), 64'h8);
    // R5: set forces masked bits of word2
    cyc("R5", '0, m2, 1'b1, adr(2'b01, 2), 32'hF0, adr(2'b00, 2));
    idle_rd("R5", m2, 2);
    check("R5", "word2", 64'(rd_data), 64'hF0);
    check("R5", "comb2 masked", 64'(comb_evt[2]), 64'h0);
    // R7: event and clear on bit3 in the same cycle
    cyc("R7", b3, '0, 1'b1, adr(2'b10, 0), 32'h8, adr(2'b00, 0));
    idle_rd("R7", '0, 0);
    check("R7", "word0 bit3", 64'(rd_data[3]), 64'h1);
    // R9: writes to flag and reserved kinds ignored
    cyc("R9", '0, '0, 1'b1, adr(2'b00, 3), 32'hFFFF_FFFF, adr(2'b00, 3));
    cyc("R9", '0, '0, 1'b1, adr(2'b11, 3), 32'hFFFF_FFFF, adr(2'b00, 3));
    idle_rd("R9", '0, 3);
    check("R9", "word3", 64'(rd_data), 64'h0);
    // R10: write-only and reserved kinds read zero
    cyc("R10", '0, '0, 1'b0, '0, '0, adr(2'b01, 2));
    cyc("R10", '0, '0, 1'b0, '0, '0, adr(2'b10, 2));
    cyc("R10", '0, '0, 1'b0, '0, '0, adr(2'b11, 0));
    check("R10", "reserved read", 64'(rd_data), 64'h0);

    // R1: reset mid-run clears everything
    m_flag = '0;
    rst = 1'b1;
    evt_pulse = ones;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "comb after reset", 64'(comb_evt), 64'h0);
    check("R1", "rd after reset", 64'(rd_data), 64'h0);
    idle_rd("R1", '0, 1);

    // random mix; R6 comb and R10 reads compared to model each cycle
    for (int t = 0; t < 4000; t++) begin
      logic [N-1:0] ev, mk;
      for (int w = 0; w < NW; w++) begin
        ev[w*W +: W] = $urandom & $urandom & $urandom & $urandom;
        mk[w*W +: W] = $urandom;
      end
      cyc((t % 2 == 0) ? "R6" : "R10", ev, mk, ($urandom % 3) == 0,
          adr(2'($urandom), int'($urandom % NW)), $urandom,
          adr(2'($urandom % 2 == 0 ? 0 : $urandom), int'($urandom % NW)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule